// File: doc/BRIEF.md
# Iterative Integer Divider with Restoring and Non-Restoring Modes

This block divides an N-bit dividend by an N-bit divisor over several clock cycles. It produces an N-bit quotient and an N-bit remainder. Each cycle it develops one quotient bit, working on a remainder register one bit wider than the operands. A mode input, sampled when the operation starts, selects one of two iteration rules. The restoring rule undoes a subtraction that went negative. The non-restoring rule keeps the negative partial remainder and adds the divisor on the next step. It then makes one correction pass at the end. Both rules give bit-identical results.

The operation starts with a single-cycle start request while the unit is idle. The result appears together with a one-cycle done pulse, and it holds until the next operation completes. A second mode input treats the operands as two's complement values. In that mode the unit divides the magnitudes, negates the quotient when the operand signs differ, and gives the remainder the sign of the dividend. A zero divisor skips the iterations and raises a flag.

Top module: `div_unit`

## Requirements
- R1: After reset, busy, done, divByZero, quotient and remainder are all zero.
- R2: With restoreMode=1 and signedMode=0, quotient = dividend / divisor and remainder = dividend % divisor for every nonzero divisor (for example 8/3 gives 2 rem 2, and 6/4 gives 1 rem 2).
- R3: With restoreMode=0 (non-restoring), results are identical to R2 for every operand pair, including the 8/3 and 6/4 cases.
- R4: done is high for exactly one cycle. With a nonzero divisor it rises after the (N+2)th clock edge following the edge that accepts start.
- R5: busy is high from the edge that accepts start until the edge that raises done. A start request while busy is ignored and does not change the running operation.
- R6: With signedMode=1 the operands are two's complement. The quotient is the magnitude quotient, negated when the signs differ. The remainder has the magnitude of the magnitude remainder and the sign of the dividend. Results are truncated to N bits.
- R7: A zero divisor sets divByZero, returns an all-ones quotient and the unmodified dividend as the remainder, and raises done after the first edge following the accepting edge, in either mode.
- R8: quotient, remainder and divByZero stay unchanged between done pulses, whatever the inputs do.
- R9: A completed division with a nonzero divisor clears divByZero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only while idle |
| restoreMode | input | 1 | 1 selects the restoring rule, 0 the non-restoring rule |
| signedMode | input | 1 | 1 treats the operands as two's complement |
| dividend | input | WIDTH | Dividend, sampled at acceptance |
| divisor | input | WIDTH | Divisor, sampled at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | WIDTH | Quotient |
| remainder | output | WIDTH | Remainder |
| divByZero | output | 1 | Last operation had a zero divisor |

## Verification
The hardest case to reach is the non-restoring final correction, where the last partial remainder is negative and must be fixed by one addition. The same applies to the signed extremes, the most negative dividend and a divisor of minus one, whose magnitudes sit on the edge of the N-bit range. A full sweep of every dividend and divisor pair at N=4, repeated in both iteration modes and both sign modes, reaches every such case. A start request injected mid-run and an input change after completion exercise the ignore and hold rules.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic load;
    logic iterate;
    logic fix;
    logic finish;
  } divStrobe_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divZero,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX, S_OUT} ctrlState_t;

  ctrlState_t state;
  logic [CW-1:0] stepCount;

  always_comb begin
    strobe.load    = (state == S_IDLE) && start;
    strobe.iterate = (state == S_RUN);
    strobe.fix     = (state == S_FIX);
    strobe.finish  = (state == S_OUT);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stepCount <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          stepCount <= CW'(WIDTH);
          state     <= divZero ? S_OUT : S_RUN;
        end
        S_RUN: begin
          stepCount <= stepCount - 1'b1;
          if (stepCount == CW'(1)) state <= S_FIX;
        end
        S_FIX: state <= S_OUT;
        S_OUT: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic             restoreMode,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);
  localparam int RW = WIDTH + 1;

  logic [RW-1:0]    remReg, divReg, shifted, combined, nextRem;
  logic [WIDTH-1:0] quoReg, absDividend, absDivisor;
  logic             restoreReg, negQuo, negRem, zeroReg, stepAdd, qBit;

  assign divZero = (divisor == '0);

  always_comb begin
    absDividend = (signedMode && dividend[WIDTH-1]) ? (~dividend + 1'b1) : dividend;
    absDivisor  = (signedMode && divisor[WIDTH-1])  ? (~divisor + 1'b1)  : divisor;
  end

  // one quotient bit per cycle; restoring keeps the shifted value on a negative trial
  always_comb begin
    shifted  = {remReg[WIDTH-1:0], quoReg[WIDTH-1]};
    stepAdd  = !restoreReg && remReg[RW-1];
    combined = stepAdd ? (shifted + divReg) : (shifted - divReg);
    qBit     = ~combined[RW-1];
    nextRem  = (restoreReg && combined[RW-1]) ? shifted : combined;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg     <= '0;
      divReg     <= '0;
      quoReg     <= '0;
      restoreReg <= 1'b0;
      negQuo     <= 1'b0;
      negRem     <= 1'b0;
      zeroReg    <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
      divByZero  <= 1'b0;
    end else begin
      if (strobe.load) begin
        remReg     <= '0;
        quoReg     <= divZero ? dividend : absDividend;
        divReg     <= {1'b0, absDivisor};
        restoreReg <= restoreMode;
        negQuo     <= signedMode && (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
        negRem     <= signedMode && dividend[WIDTH-1];
        zeroReg    <= divZero;
      end
      if (strobe.iterate) begin
        remReg <= nextRem;
        quoReg <= {quoReg[WIDTH-2:0], qBit};
      end
      if (strobe.fix && remReg[RW-1]) begin
        remReg <= remReg + divReg;
      end
      if (strobe.finish) begin
        divByZero <= zeroReg;
        if (zeroReg) begin
          quotient  <= '1;
          remainder <= quoReg;
        end else begin
          quotient  <= negQuo ? (~quoReg + 1'b1) : quoReg;
          remainder <= negRem ? (~remReg[WIDTH-1:0] + 1'b1) : remReg[WIDTH-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             restoreMode,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);
  divStrobe_t strobe;
  logic       divZero;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .divZero(divZero),
    .strobe(strobe), .busy(busy), .done(done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .restoreMode(restoreMode),
    .signedMode(signedMode), .dividend(dividend), .divisor(divisor),
    .divZero(divZero), .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero)
  );
endmodule

// File: rtl/div_unit_checker.sv
module div_unit_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             signedMode,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             divByZero
);
  logic [WIDTH-1:0] capA, capB;
  logic             capSigned;
  logic [2*WIDTH-1:0] rebuilt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA <= '0; capB <= '0; capSigned <= 1'b0;
    end else if (start && !busy) begin
      capA <= dividend; capB <= divisor; capSigned <= signedMode;
    end
  end

  assign rebuilt = (2*WIDTH)'(quotient) * (2*WIDTH)'(capB) + (2*WIDTH)'(remainder);

  // R2 and R3: unsigned results satisfy the division identity in either mode
  assert_identity_R2_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !capSigned && capB != '0) |-> (rebuilt == (2*WIDTH)'(capA) && remainder < capB));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && divByZero) |-> (quotient == '1 && remainder == capA));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(divByZero)));
endmodule

bind div_unit div_unit_checker #(.WIDTH(WIDTH)) u_div_unit_checker (
  .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
  .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
);

// File: tb/test_div_unit.sv
`timescale 1ns/1ps
module test_div_unit;
  localparam int W = 4;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, restoreMode = 1'b1, signedMode = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, divByZero;
  logic [W-1:0] quotient, remainder;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  div_unit #(.WIDTH(W)) i_div_unit (
    .clk(clk), .rstN(rstN), .start(start), .restoreMode(restoreMode),
    .signedMode(signedMode), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    int ia, ib, ma, mb, iq, ir;
    if (b == '0) begin
      q = '1; r = a;
    end else if (!sgn) begin
      q = a / b; r = a % b;
    end else begin
      ia = a[W-1] ? int'(a) - (1 << W) : int'(a);
      ib = b[W-1] ? int'(b) - (1 << W) : int'(b);
      ma = (ia < 0) ? -ia : ia;
      mb = (ib < 0) ? -ib : ib;
      iq = ma / mb; ir = ma % mb;
      if ((ia < 0) != (ib < 0)) iq = -iq;
      if (ia < 0) ir = -ir;
      q = iq[W-1:0]; r = ir[W-1:0];
    end
  endfunction

  // drives at a falling edge; returns the number of rising edges until done is seen
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic rst,
                       input logic sgn, input logic midStart, output int edges);
    restoreMode = rst; signedMode = sgn; dividend = a; divisor = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    edges = 1;
    start = 1'b0;
    if (midStart) begin
      dividend = ~a; divisor = 1; restoreMode = ~rst; start = 1'b1;
    end
    while (!done && edges < 50) begin
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      edges++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] eq, er;
    int edges;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {busy, done, divByZero, quotient, remainder}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // named cases: R2 restoring, R3 non-restoring
    for (int m = 0; m < 2; m++) begin
      runOp(4'd8, 4'd3, m[0], 1'b0, 1'b0, edges);
      check(m ? "R2 8/3" : "R3 8/3", {quotient, remainder}, {4'd2, 4'd2});
      runOp(4'd6, 4'd4, m[0], 1'b0, 1'b0, edges);
      check(m ? "R2 6/4" : "R3 6/4", {quotient, remainder}, {4'd1, 4'd2});
      check("R4 latency", edges, W + 3);
      @(posedge clk); @(negedge clk);
      check("R4 one-cycle done", done, 1'b0);
    end

    // exhaustive sweep, both iteration rules and both sign modes
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            runOp(a[W-1:0], b[W-1:0], m[0], s[0], 1'b0, edges);
            model(a[W-1:0], b[W-1:0], s[0], eq, er);
            if (b == 0)
              check("R7 zero divisor", {divByZero, quotient, remainder, 8'(edges)},
                    {1'b1, eq, er, 8'd2});
            else if (s == 1)
              check("R6 signed", {divByZero, quotient, remainder, 8'(edges)},
                    {1'b0, eq, er, 8'(W + 3)});
            else
              check(m ? "R2 restoring" : "R3 non-restoring",
                    {divByZero, quotient, remainder, 8'(edges)}, {1'b0, eq, er, 8'(W + 3)});
          end

    // R5 start while busy is ignored
    runOp(4'd13, 4'd5, 1'b0, 1'b0, 1'b1, edges);
    check("R5 start ignored while busy", {quotient, remainder, 8'(edges)}, {4'd2, 4'd3, 8'(W + 3)});
    check("R5 idle after done", busy, 1'b0);

    // R8 outputs hold while inputs change
    dividend = 4'd15; divisor = 4'd0; signedMode = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 hold", {divByZero, quotient, remainder}, {1'b0, 4'd2, 4'd3});

    // R9 flag cleared by a normal division
    runOp(4'd9, 4'd0, 1'b1, 1'b0, 1'b0, edges);
    check("R7 flag set", divByZero, 1'b1);
    runOp(4'd9, 4'd2, 1'b1, 1'b0, 1'b0, edges);
    check("R9 flag cleared", {divByZero, quotient, remainder}, {1'b0, 4'd4, 4'd1});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule